// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block decides where a small I/O processor fetches its next instruction. It keeps a 12-bit program counter and a four-entry hardware stack of return addresses. On each cycle in which the step strobe is high, it takes a decoded flow-control operation, a target address and the current zero flag, and it produces the next program counter. The supported operations are plain advance, unconditional jump, subroutine call, subroutine return, branch when the zero flag is set, and branch when the zero flag is clear.

A call pushes the address that follows the current one and then moves to the target. A return pops the most recent of those addresses and resumes there. A halt needs no operation of its own: a branch whose target is the current address keeps the counter fixed for as long as it is repeated. Pushing onto a full stack and popping from an empty one are both caught. In each case the operation continues in a defined way, and a one-cycle indication is raised.

Instruction memory and instruction decode sit outside the block. The instruction decoder drives the operation select and the target address. The ALU drives the zero flag.

Top module: `flow_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, empties the stack, and clears both error indications. A return issued after reset reports underflow.
- R2: While the step input is low, the PC and the stack contents hold. Both error indications are low in the cycle that follows.
- R3: With step high, opSel values 0, 6 and 7 advance the PC by one. The PC wraps from 0xFFF to 0x000.
- R4: opSel 1 (jump) loads the target into the PC and leaves the stack unchanged.
- R5: opSel 2 (call) pushes the current PC plus one, wrapping at 12 bits, and loads the target into the PC.
- R6: opSel 3 (return) loads the PC from the most recently pushed entry and removes that entry, so entries come back in last-in, first-out order.
- R7: opSel 4 (branch if zero) loads the target when zeroFlag is 1. Otherwise it advances the PC by one.
- R8: opSel 5 (branch if not zero) loads the target when zeroFlag is 0. Otherwise it advances the PC by one.
- R9: A taken branch or jump whose target equals the current PC keeps the PC unchanged on every step (halt).
- R10: A call issued while four entries are held still loads the target, but it does not store the return address. stackOverflow is high for exactly the one cycle after that step edge.
- R11: A return issued while the stack is empty advances the PC by one and leaves the stack empty. stackUnderflow is high for exactly the one cycle after that step edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance strobe; the operation is applied only when this is high |
| opSel | input | 3 | Flow operation: 0 advance, 1 jump, 2 call, 3 return, 4 branch if zero, 5 branch if not zero, 6/7 advance |
| target | input | 12 | Destination address for jump, call and branches |
| zeroFlag | input | 1 | Zero condition from the ALU |
| pc | output | 12 | Current program counter |
| stackOverflow | output | 1 | One-cycle pulse after a call that found the stack full |
| stackUnderflow | output | 1 | One-cycle pulse after a return that found the stack empty |

## Verification
The hardest state to reach is a full stack whose contents are known exactly. Random operations rarely string together four calls without a return in between, and only that state shows both the dropped push and the unchanged contents left behind it. Directed sequences therefore issue five calls in a row, with distinct targets and some starting at 0xFFF, and then unwind with six returns. That sequence checks the overflow pulse, the last-in, first-out order, the wrapped return address and the final underflow, all through the PC. Long random runs with a biased operation mix then cover calls and returns at arbitrary depths against a reference model in the bench.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  // Encoding of the operation select input.
  typedef enum logic [2:0] {
    OP_ADVANCE = 3'd0,
    OP_JUMP    = 3'd1,
    OP_CALL    = 3'd2,
    OP_RETURN  = 3'd3,
    OP_BRZERO  = 3'd4,
    OP_BRNZERO = 3'd5
  } flowOp_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic advance;        // PC <= PC + 1
    logic takeTarget;     // PC <= target
    logic takeReturn;     // PC <= top of stack
    logic push;           // store PC + 1 on the stack
    logic pop;            // drop the top entry
    logic raiseOverflow;  // a push was refused
    logic raiseUnderflow; // a pop was refused
  } seqStrobes_t;

endpackage

// File: rtl/flow_seq_ctrl.sv
module flow_seq_ctrl
  import flow_seq_pkg::*;
(
  input  logic        step,
  input  logic [2:0]  opSel,
  input  logic        zeroFlag,
  input  logic        stackFull,
  input  logic        stackEmpty,
  output seqStrobes_t ctl
);

  logic branchTaken;

  // Condition is evaluated only for the two branch codes.
  always_comb begin
    branchTaken = 1'b0;
    if (opSel == OP_BRZERO)  branchTaken = zeroFlag;
    if (opSel == OP_BRNZERO) branchTaken = ~zeroFlag;
  end

  always_comb begin
    ctl = '0;
    if (step) begin
      unique case (opSel)
        OP_JUMP: ctl.takeTarget = 1'b1;
        OP_CALL: begin
          ctl.takeTarget = 1'b1;
          if (stackFull) ctl.raiseOverflow = 1'b1;
          else           ctl.push          = 1'b1;
        end
        OP_RETURN: begin
          if (stackEmpty) begin
            ctl.advance        = 1'b1;
            ctl.raiseUnderflow = 1'b1;
          end else begin
            ctl.takeReturn = 1'b1;
            ctl.pop        = 1'b1;
          end
        end
        OP_BRZERO, OP_BRNZERO: begin
          ctl.takeTarget = branchTaken;
          ctl.advance    = ~branchTaken;
        end
        default: ctl.advance = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/flow_seq_path.sv
module flow_seq_path
  import flow_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobes_t     ctl,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic            stackFull,
  output logic            stackEmpty,
  output logic            stackOverflow,
  output logic            stackUnderflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] depthCount;
  logic [PC_W-1:0]  entries [DEPTH];
  logic [PC_W-1:0]  topEntry;
  logic [PC_W-1:0]  pcInc;
  logic [PC_W-1:0]  pcNext;

  assign pcInc      = pc + PC_W'(1);
  assign stackFull  = (depthCount == CNT_W'(DEPTH));
  assign stackEmpty = (depthCount == '0);

  // Return address storage: entry i is written when it is the next free slot.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        entries[i] <= '0;
      else if (ctl.push && depthCount == CNT_W'(i))
        entries[i] <= pcInc;
    end
  end

  // Most recent entry sits just below the fill count.
  always_comb begin
    topEntry = '0;
    for (int i = 0; i < DEPTH; i++)
      if (depthCount == CNT_W'(i + 1)) topEntry = entries[i];
  end

  always_ff @(posedge clk) begin
    if (rst)           depthCount <= '0;
    else if (ctl.push) depthCount <= depthCount + CNT_W'(1);
    else if (ctl.pop)  depthCount <= depthCount - CNT_W'(1);
  end

  always_comb begin
    pcNext = pc;
    if (ctl.takeTarget)      pcNext = target;
    else if (ctl.takeReturn) pcNext = topEntry;
    else if (ctl.advance)    pcNext = pcInc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc             <= '0;
      stackOverflow  <= 1'b0;
      stackUnderflow <= 1'b0;
    end else begin
      pc             <= pcNext;
      stackOverflow  <= ctl.raiseOverflow;
      stackUnderflow <= ctl.raiseUnderflow;
    end
  end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [2:0]      opSel,
  input  logic [PC_W-1:0] target,
  input  logic            zeroFlag,
  output logic [PC_W-1:0] pc,
  output logic            stackOverflow,
  output logic            stackUnderflow
);

  seqStrobes_t ctl;
  logic        stackFull;
  logic        stackEmpty;

  flow_seq_ctrl u_ctrl (
    .step       (step),
    .opSel      (opSel),
    .zeroFlag   (zeroFlag),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .ctl        (ctl)
  );

  flow_seq_path #(.PC_W(PC_W), .DEPTH(DEPTH)) u_path (
    .clk            (clk),
    .rst            (rst),
    .ctl            (ctl),
    .target         (target),
    .pc             (pc),
    .stackFull      (stackFull),
    .stackEmpty     (stackEmpty),
    .stackOverflow  (stackOverflow),
    .stackUnderflow (stackUnderflow)
  );

endmodule

// File: rtl/flow_sequencer_checker.sv
module flow_sequencer_checker #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            step,
  input logic [2:0]      opSel,
  input logic [PC_W-1:0] target,
  input logic            zeroFlag,
  input logic [PC_W-1:0] pc,
  input logic            stackOverflow,
  input logic            stackUnderflow
);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && !stackOverflow && !stackUnderflow));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc) && !stackOverflow && !stackUnderflow));

  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (step && opSel == 3'd1) |=> pc == $past(target));

  assert_call_R5: assert property (@(posedge clk) disable iff (rst)
    (step && opSel == 3'd2) |=> pc == $past(target));

  assert_brz_R7: assert property (@(posedge clk) disable iff (rst)
    (step && opSel == 3'd4) |=>
      pc == ($past(zeroFlag) ? $past(target) : $past(pc) + PC_W'(1)));

  assert_brnz_R8: assert property (@(posedge clk) disable iff (rst)
    (step && opSel == 3'd5) |=>
      pc == (!$past(zeroFlag) ? $past(target) : $past(pc) + PC_W'(1)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    stackOverflow |-> $past(step && opSel == 3'd2));

  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
    stackUnderflow |-> ($past(step && opSel == 3'd3) && pc == $past(pc) + PC_W'(1)));

  assert_flags_R10_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stackOverflow, stackUnderflow}));

endmodule

bind flow_sequencer flow_sequencer_checker #(.PC_W(PC_W)) u_checker (
  .clk            (clk),
  .rst            (rst),
  .step           (step),
  .opSel          (opSel),
  .target         (target),
  .zeroFlag       (zeroFlag),
  .pc             (pc),
  .stackOverflow  (stackOverflow),
  .stackUnderflow (stackUnderflow)
);

// File: tb/flow_sequencer_tb.sv
module flow_sequencer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [11:0] target = 12'd0;
  logic        zeroFlag = 1'b0;
  logic [11:0] pc;
  logic        stackOverflow;
  logic        stackUnderflow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  logic [11:0] mPc;
  logic [11:0] mStack [4];
  int          mCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flow_sequencer u_dut (
    .clk(clk), .rst(rst), .step(step), .opSel(opSel), .target(target),
    .zeroFlag(zeroFlag), .pc(pc), .stackOverflow(stackOverflow),
    .stackUnderflow(stackUnderflow)
  );

  function automatic logic branchTaken(input logic [2:0] op, input logic z);
    return (op == 3'd4 && z) || (op == 3'd5 && !z);
  endfunction

  task automatic check(input string tag, input logic [11:0] ePc,
                       input logic eOv, input logic eUn);
    checks++;
    if (pc !== ePc || stackOverflow !== eOv || stackUnderflow !== eUn) begin
      fails++;
      $display("FAIL %s: pc=%h ovf=%b unf=%b expected pc=%h ovf=%b unf=%b",
               tag, pc, stackOverflow, stackUnderflow, ePc, eOv, eUn);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check after the next rise.
  task automatic cycle(input logic st, input logic [2:0] op,
                       input logic [11:0] tg, input logic z, input string tag);
    logic eOv = 1'b0;
    logic eUn = 1'b0;
    step = st; opSel = op; target = tg; zeroFlag = z;
    if (st) begin
      case (op)
        3'd1: mPc = tg;
        3'd2: begin
          if (mCount == 4) eOv = 1'b1;
          else begin mStack[mCount] = mPc + 12'd1; mCount++; end
          mPc = tg;
        end
        3'd3: begin
          if (mCount == 0) begin eUn = 1'b1; mPc = mPc + 12'd1; end
          else begin mCount--; mPc = mStack[mCount]; end
        end
        3'd4, 3'd5: mPc = branchTaken(op, z) ? tg : mPc + 12'd1;
        default: mPc = mPc + 12'd1;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, mPc, eOv, eUn);
  endtask

  task automatic doReset();
    rst = 1'b1; step = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mPc = 12'd0; mCount = 0;
    check("R1 reset", 12'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_1234));
    @(negedge clk);
    doReset();

    // R3: advance codes and wrap
    cycle(1, 3'd0, 12'h000, 0, "R3 advance");
    cycle(1, 3'd6, 12'h123, 1, "R3 code6");
    cycle(1, 3'd7, 12'h123, 0, "R3 code7");
    cycle(1, 3'd1, 12'hFFF, 0, "R4 jump to top");
    cycle(1, 3'd0, 12'h000, 0, "R3 wrap");

    // R2: step low holds everything
    cycle(0, 3'd1, 12'h555, 0, "R2 hold jump");
    cycle(0, 3'd2, 12'h666, 0, "R2 hold call");
    cycle(1, 3'd3, 12'h000, 0, "R2 stack untouched (underflow) R11");

    // R7/R8 both ways
    cycle(1, 3'd4, 12'h200, 1, "R7 bz taken");
    cycle(1, 3'd4, 12'h300, 0, "R7 bz not taken");
    cycle(1, 3'd5, 12'h400, 0, "R8 bnz taken");
    cycle(1, 3'd5, 12'h500, 1, "R8 bnz not taken");

    // R9: halt loops
    for (int i = 0; i < 3; i++) cycle(1, 3'd4, mPc, 1, "R9 halt bz");
    for (int i = 0; i < 3; i++) cycle(1, 3'd5, mPc, 0, "R9 halt bnz");
    cycle(1, 3'd1, mPc, 0, "R9 halt jmp");

    // R5/R6/R10: fill stack, overflow, unwind, R11 underflow
    cycle(1, 3'd1, 12'hFFF, 0, "R4 jump");
    cycle(1, 3'd2, 12'h010, 0, "R5 call wraps return addr");
    cycle(1, 3'd2, 12'h020, 0, "R5 call 2");
    cycle(1, 3'd2, 12'h030, 0, "R5 call 3");
    cycle(1, 3'd2, 12'h040, 0, "R5 call 4");
    cycle(1, 3'd2, 12'h050, 0, "R10 overflow call");
    cycle(1, 3'd0, 12'h000, 0, "R10 pulse clears");
    for (int i = 0; i < 4; i++) cycle(1, 3'd3, 12'h000, 0, "R6 lifo return");
    cycle(1, 3'd3, 12'h000, 0, "R11 underflow");
    cycle(1, 3'd3, 12'h000, 0, "R11 underflow again");

    // R1: reset empties a non-empty stack
    cycle(1, 3'd2, 12'h0AA, 0, "R5 call before reset");
    doReset();
    cycle(1, 3'd3, 12'h000, 0, "R1 stack empty after reset");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] op;
      if (r < 25)      op = 3'd2;
      else if (r < 50) op = 3'd3;
      else             op = 3'($urandom_range(0, 7));
      cycle($urandom_range(0, 9) != 0, op, 12'($urandom()),
            1'($urandom()), "RND R3 R4 R5 R6 R7 R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule